// File: doc/BRIEF.md
# Multi-Channel Debounced Pin Edge Detector

This block conditions three independent external pins for a synchronous core. Each raw pin first passes through a two-flop synchroniser. It is then examined only on a sampling tick that fires on every second system-clock cycle. A new level is accepted only after the same value has been seen on four consecutive ticks, so short glitches never reach the filtered level.

Every channel turns its filtered level into single-cycle rising and falling edge pulses. Each edge direction on each channel has its own enable bit. The filtered levels themselves are always visible, whatever the enables are set to.

Detection latency is fixed and short. At a 25 MHz system clock the tick rate is 12.5 MHz, so a pulse must last at least 0.32 µs to be recognised.

Top module: `pin_edge_filter`

## Requirements
- R1: Each pin passes through a two-flop synchroniser and is sampled only on a tick that fires on every second clock cycle. The first tick falls on the second cycle after reset is released.
- R2: The filtered level takes a new value on the tick that gives the fourth consecutive identical sample of that value, and at no other time.
- R3: A high pulse that lasts 1, 2 or exactly 3 samples (2, 4 or 6 clock cycles) leaves the filtered level at 0 and produces no edge pulse.
- R4: A sample that differs from the one before it restarts the run count. So 3 high samples, then 1 low sample, then 4 high samples give exactly one rising edge.
- R5: When the filtered level goes from 0 to 1 and the channel's rise enable bit is 1, `rise_o[ch]` is high for exactly one clock cycle. When that enable bit is 0, `rise_o[ch]` stays 0.
- R6: When the filtered level goes from 1 to 0 and the channel's fall enable bit is 1, `fall_o[ch]` is high for exactly one clock cycle. When that enable bit is 0, `fall_o[ch]` stays 0.
- R7: The edge enable bits have no effect on `level_o`. A pulse of 4 or more samples drives the level high even when both enables of its channel are 0.
- R8: A rising edge pulse appears 9 or 10 clock cycles after the first clock edge at which the raw pin is high. The count is 10 when the pin is already high while reset is released.
- R9: Synchronous active-low reset forces every filtered level to 0, clears the synchronisers and run counters, and raises no edge pulse during reset or in the cycle after it. A level that reset pulls down gives no falling pulse.
- R10: The channels are independent: activity on one pin causes no pulse and no level change on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 3 | Raw asynchronous pin inputs, one bit per channel |
| rise_en_i | input | 3 | Rising-edge pulse enable, one bit per channel |
| fall_en_i | input | 3 | Falling-edge pulse enable, one bit per channel |
| level_o | output | 3 | Filtered level, one bit per channel |
| rise_o | output | 3 | One-cycle rising-edge pulse, one bit per channel |
| fall_o | output | 3 | One-cycle falling-edge pulse, one bit per channel |

## Verification
The assertions check several properties on every cycle:
- the sampling tick never fires on two cycles in a row;
- a filtered level moves only on a tick, and only with a full run of four matching samples behind it;
- edge pulses last one cycle, follow their enable and the level direction, and are never high together;
- nothing pulses just after reset.

Only the bench scenarios can show the rest:
- the exact cut-off between rejected 3-sample glitches and accepted 4-sample pulses;
- the restart of a run after one differing sample;
- the 9-to-10-cycle latency;
- independence between channels;
- the absence of a falling pulse when reset pulls a level down.

// File: rtl/pin_filt_pkg.sv
// Package: shared types for the pin edge filter.
// Assumes: nothing beyond IEEE 1800-2017.
package pin_filt_pkg;

    // Pair of edge indications produced by one channel.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

endpackage

// File: rtl/sample_tick.sv
// Module: sample_tick
// Produces a one-cycle tick every DIV clock cycles. With DIV = 2 this
// sets the sampling rate to half the system clock.
// Assumes: DIV >= 2, synchronous active-low reset.
module sample_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Free-running divider counter that wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    // R1: a tick never lasts two consecutive cycles
    a_r1_tick_not_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && tick_o) |=> !tick_o);

endmodule

// File: rtl/pin_sync.sv
// Module: pin_sync
// Multi-flop synchroniser that brings one asynchronous pin into the
// clock domain.
// Assumes: STAGES >= 2; resets to 0.
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/run_filter.sv
// Module: run_filter
// Digital noise filter. On each sample tick it compares the synchronised
// input with the previous sample and counts the run of identical values.
// The filtered level takes a value on the tick that completes a run of
// ACCEPT_RUN matching samples.
// Assumes: sample_i is already synchronous; ACCEPT_RUN >= 2.
module run_filter #(
    parameter int ACCEPT_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_en_i,
    input  logic sample_i,
    output logic level_o
);
    localparam int RUN_W = $clog2(ACCEPT_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ACCEPT_RUN);

    logic             last_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nx;
    logic             level_q;

    // Next run length: restart at 1 on a change, otherwise count up and saturate.
    always_comb begin
        if (sample_i != last_q)
            run_nx = RUN_W'(1);
        else if (run_q == RUN_MAX)
            run_nx = run_q;
        else
            run_nx = run_q + 1'b1;
    end

    // Update sample history, run length and filtered level on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= 1'b0;
            run_q   <= '0;
            level_q <= 1'b0;
        end else if (samp_en_i) begin
            last_q <= sample_i;
            run_q  <= run_nx;
            if (run_nx == RUN_MAX)
                level_q <= sample_i;
        end
    end

    assign level_o = level_q;

    // R2: between ticks the level holds
    a_r2_level_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !samp_en_i) |=> $stable(level_q));

    // R2: a level change always has a full run of matching samples behind it
    a_r2_change_needs_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && !$stable(level_q)) |-> (run_q == RUN_MAX && level_q == last_q));

    // R4: the run counter never exceeds its saturation value
    a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX);

endmodule

// File: rtl/edge_pulse.sv
// Module: edge_pulse
// Turns one filtered level into enable-gated, one-cycle rise and fall
// pulses by comparing it with its value one cycle earlier.
// Assumes: level_i comes from a register in the same clock domain.
module edge_pulse
    import pin_filt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic       rise_en_i,
    input  logic       fall_en_i,
    output edge_pair_t pulse_o
);
    logic level_d_q;

    // Remember the previous level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_d_q <= 1'b0;
        else
            level_d_q <= level_i;
    end

    // Form gated edge pulses from the level and its delayed copy.
    always_comb begin
        pulse_o.rise = rise_en_i &  level_i & ~level_d_q;
        pulse_o.fall = fall_en_i & ~level_i &  level_d_q;
    end

    // R5: a rising pulse lasts one cycle
    a_r5_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pulse_o.rise) |=> !pulse_o.rise);

    // R5: a rising pulse needs the enable and a high level
    a_r5_rise_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o.rise |-> (rise_en_i && level_i));

    // R6: a falling pulse lasts one cycle
    a_r6_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pulse_o.fall) |=> !pulse_o.fall);

    // R6: a falling pulse needs the enable and a low level
    a_r6_fall_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o.fall |-> (fall_en_i && !level_i));

    // R6: rise and fall are never high together
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_o.rise && pulse_o.fall));

endmodule

// File: rtl/pin_edge_filter.sv
// Module: pin_edge_filter (top)
// Per-channel synchroniser, run-length noise filter and edge pulse
// generator, all driven by one shared half-rate sampling tick.
// Assumes: synchronous active-low reset; the pins are asynchronous.
module pin_edge_filter
    import pin_filt_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLE_DIV  = 2,
    parameter int ACCEPT_RUN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [NUM_CH-1:0] rise_en_i,
    input  logic [NUM_CH-1:0] fall_en_i,
    output logic [NUM_CH-1:0] level_o,
    output logic [NUM_CH-1:0] rise_o,
    output logic [NUM_CH-1:0] fall_o
);
    logic samp_tick;

    sample_tick #(.DIV(SAMPLE_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (samp_tick)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic       sync_pin;
        logic       lvl;
        edge_pair_t pulses;

        pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (pin_i[ch]),
            .sync_o  (sync_pin)
        );

        run_filter #(.ACCEPT_RUN(ACCEPT_RUN)) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .samp_en_i (samp_tick),
            .sample_i  (sync_pin),
            .level_o   (lvl)
        );

        edge_pulse u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_i   (lvl),
            .rise_en_i (rise_en_i[ch]),
            .fall_en_i (fall_en_i[ch]),
            .pulse_o   (pulses)
        );

        assign level_o[ch] = lvl;
        assign rise_o[ch]  = pulses.rise;
        assign fall_o[ch]  = pulses.fall;
    end

    // R9: no edge pulse in the cycle after a reset cycle
    a_r9_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (rise_o == '0 && fall_o == '0));

endmodule

// File: tb/tb_pin_edge_filter.sv
`timescale 1ns/1ps
module tb_pin_edge_filter;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pin = '0;
    logic [NCH-1:0] ren = '0;
    logic [NCH-1:0] fen = '0;
    logic [NCH-1:0] level, rise, fall;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    pin_edge_filter dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .rise_en_i(ren), .fall_en_i(fall_en_i_w),
        .level_o(level), .rise_o(rise), .fall_o(fall)
    );
    logic [NCH-1:0] fall_en_i_w;
    assign fall_en_i_w = fen;

    // Monitor: runs 1 ns after each rising edge.
    int cyc = 0;
    int rise_cnt [NCH];
    int fall_cnt [NCH];
    int first_rise [NCH];
    bit hi_seen [NCH];
    always @(posedge clk) begin
        #1;
        cyc++;
        for (int c = 0; c < NCH; c++) begin
            if (rise[c]) begin
                rise_cnt[c]++;
                if (first_rise[c] < 0) first_rise[c] = cyc;
            end
            if (fall[c]) fall_cnt[c]++;
            if (level[c]) hi_seen[c] = 1;
        end
    end

    task automatic clear_mon();
        for (int c = 0; c < NCH; c++) begin
            rise_cnt[c] = 0; fall_cnt[c] = 0; first_rise[c] = -1; hi_seen[c] = 0;
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Vector: {ch[2], width_samples[6], ren, fen, exp_rise, exp_fall}
    localparam int NV = 11;
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 6'd1, 1'b1, 1'b1, 1'b0, 1'b0},   // R3 one-sample glitch
        {2'd0, 6'd2, 1'b1, 1'b1, 1'b0, 1'b0},   // R3 two-sample glitch
        {2'd0, 6'd3, 1'b1, 1'b1, 1'b0, 1'b0},   // R3 three-sample glitch
        {2'd0, 6'd4, 1'b1, 1'b1, 1'b1, 1'b1},   // R2 minimum accepted
        {2'd1, 6'd5, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd2, 6'd4, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd1, 6'd6, 1'b0, 1'b1, 1'b0, 1'b1},   // R5 rise disabled
        {2'd2, 6'd6, 1'b1, 1'b0, 1'b1, 1'b0},   // R6 fall disabled
        {2'd2, 6'd3, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd0, 6'd8, 1'b0, 1'b0, 1'b0, 1'b0},   // R7 both disabled
        {2'd1, 6'd3, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    initial begin
        clear_mon();
        // Reset state (R9)
        wait_cyc(4);
        chk(level == '0, "R9", "level during reset", level, 0);
        chk(rise == '0 && fall == '0, "R9", "pulses during reset", {rise, fall}, 0);
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(12);
        chk(level == '0, "R9", "level after reset with pins low", level, 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            int ch, w, t0;
            bit er, ef, exp_hi;
            ch = int'(VEC[v][11:10]);
            w  = int'(VEC[v][9:4]);
            er = VEC[v][1]; ef = VEC[v][0];
            exp_hi = (w >= 4);
            @(negedge clk);
            ren = '0; fen = '0;
            ren[ch] = VEC[v][3]; fen[ch] = VEC[v][2];
            clear_mon();
            t0 = cyc;
            pin[ch] = 1'b1;
            wait_cyc(2 * w);
            pin[ch] = 1'b0;
            wait_cyc(30);
            chk(rise_cnt[ch] == int'(er), "R3/R5", $sformatf("vec %0d rise pulses", v), rise_cnt[ch], int'(er));
            chk(fall_cnt[ch] == int'(ef), "R3/R6", $sformatf("vec %0d fall pulses", v), fall_cnt[ch], int'(ef));
            chk(hi_seen[ch] == exp_hi, "R2/R7", $sformatf("vec %0d level went high", v), hi_seen[ch], exp_hi);
            chk(level[ch] == 1'b0, "R2", $sformatf("vec %0d final level", v), level[ch], 0);
            if (er)
                chk(first_rise[ch] - t0 >= 9 && first_rise[ch] - t0 <= 10, "R8",
                    $sformatf("vec %0d rise latency", v), first_rise[ch] - t0, 9);
            for (int c = 0; c < NCH; c++)
                if (c != ch)
                    chk(rise_cnt[c] == 0 && fall_cnt[c] == 0 && !hi_seen[c], "R10",
                        $sformatf("vec %0d channel %0d disturbed", v, c), rise_cnt[c] + fall_cnt[c], 0);
        end

        // R4: 3 high, 1 low, 4 high -> exactly one rise and one fall
        @(negedge clk); ren = '1; fen = '1; clear_mon();
        pin[2] = 1'b1; wait_cyc(6);
        pin[2] = 1'b0; wait_cyc(2);
        pin[2] = 1'b1; wait_cyc(8);
        pin[2] = 1'b0; wait_cyc(30);
        chk(rise_cnt[2] == 1, "R4", "rise count after restarted run", rise_cnt[2], 1);
        chk(fall_cnt[2] == 1, "R4", "fall count after restarted run", fall_cnt[2], 1);

        // R3: burst of alternating single-sample glitches
        @(negedge clk); clear_mon();
        for (int k = 0; k < 20; k++) begin
            pin[1] = ~pin[1]; wait_cyc(2);
        end
        pin[1] = 1'b0; wait_cyc(20);
        chk(rise_cnt[1] == 0 && !hi_seen[1], "R3", "alternating glitches accepted", rise_cnt[1], 0);

        // R10: all channels together, 5 samples each
        @(negedge clk); clear_mon();
        pin = '1; wait_cyc(10);
        pin = '0; wait_cyc(30);
        for (int c = 0; c < NCH; c++)
            chk(rise_cnt[c] == 1 && fall_cnt[c] == 1, "R10",
                $sformatf("channel %0d simultaneous pulse", c), rise_cnt[c] * 10 + fall_cnt[c], 11);

        // R9: reset while a level is high; no fall, then re-detect with latency 10
        @(negedge clk); clear_mon();
        pin[0] = 1'b1; wait_cyc(20);
        chk(level[0] == 1'b1, "R9", "level high before reset", level[0], 1);
        clear_mon();
        rst_n = 1'b0; wait_cyc(1);
        chk(level[0] == 1'b0, "R9", "level cleared by reset", level[0], 0);
        wait_cyc(2);
        begin
            int t0;
            rst_n = 1'b1;
            t0 = cyc;
            wait_cyc(16);
            chk(fall_cnt[0] == 0, "R9", "fall pulse caused by reset", fall_cnt[0], 0);
            chk(first_rise[0] - t0 == 10, "R8", "rise latency after reset release", first_rise[0] - t0, 10);
        end
        pin = '0; wait_cyc(20);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule